// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block is a synthesizable model of the write-command front end of a small-sector parallel NOR flash. The chip-enable, write-enable and output-enable strobes arrive asynchronously. The block samples them, together with the address and data buses, in its own system clock domain. A write bus cycle exists only while chip enable and write enable are both low. Its address is taken at the moment the later of the two strobes falls. Its data is taken at the moment the earlier of the two rises. The address and data pass through the same synchronizer depth as the strobes, so each is captured in the same sample as the strobe edge.

Successive write cycles are matched against unlock sequences. A four-cycle sequence programs one byte. Two six-cycle sequences erase either one 128-byte sector or the whole array. A recognised command starts an internal busy phase with a parameterized length. During that phase every further write cycle is discarded. A read during the busy phase returns status instead of array data: bit 7 is the complement of the target value's bit 7, and bit 6 flips on every read. Once the busy phase ends, reads return array contents again. The array is held in flops and starts erased.

Top module: `nor_flash_cmd`

## Requirements
- R1: `dqDrive` is 1 exactly while `ceN` and `oeN` are both low. When it is 1 and no operation is running, `dqOut` equals the array byte at address bits [IDX_W-1:0].
- R2: A write cycle uses the address present when the later of `ceN`/`weN` falls. It uses the data present when the earlier of the two rises. Bus changes after those edges have no effect.
- R3: The byte-program sequence has four write cycles: AAH at 5555H, 55H at 2AAAH, A0H at 5555H, then the target address and data. It starts a program of that byte.
- R4: A program stores the bitwise AND of the old byte and the written data, so it can only clear bits.
- R5: The sector-erase sequence has six write cycles: AAH@5555H, 55H@2AAAH, 80H@5555H, AAH@5555H, 55H@2AAAH, then 20H at any address. It sets all bytes of the SECTOR-byte sector holding that address to FFH and leaves the other sectors unchanged.
- R6: The same sequence with 10H at 5555H in the sixth cycle sets every array byte to FFH. A 10H at any other address starts nothing.
- R7: A write cycle whose address or data does not fit the expected step of a sequence returns the decoder to idle. It starts no operation, including the program that a following data cycle would otherwise cause.
- R8: A started operation keeps the block busy for PROG_CYC, SEC_CYC or CHIP_CYC clocks and never longer than the largest of them. After that, reads return true array data.
- R9: While busy, read bit 7 is the complement of the target bit 7: ~data[7] for a program, 0 for an erase. Read bit 6 differs between consecutive reads.
- R10: Write cycles that arrive while busy are ignored. A full program sequence issued during an erase leaves its target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; the array resets erased |
| ceN | input | 1 | Chip enable, active low, asynchronous |
| weN | input | 1 | Write enable, active low, asynchronous |
| oeN | input | 1 | Output enable, active low, asynchronous |
| addr | input | 16 | Byte address bus |
| dqIn | input | 8 | Data bus into the block |
| dqOut | output | 8 | Read data or status |
| dqDrive | output | 1 | Data-bus output enable (0 = high impedance) |

## Verification
On every cycle, the assertions check the output-enable gating, that at most one operation starts at a time, and that a start leads into a busy phase. They also check that no start occurs while busy, that the busy run is bounded by the longest duration, and that bit 6 flips after each read while busy. The bench's scenarios alone show the array effects and the sequence matching. These cover AND-only programming, sector-limited and whole-array erase, and rejection of wrong unlock bytes or addresses. They also cover the skewed-strobe capture of address and data, and that commands issued during an erase are ignored.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;
  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] UNLOCK_A = 16'h5555;
  localparam logic [ADDR_W-1:0] UNLOCK_B = 16'h2AAA;

  localparam logic [7:0] KEY_A    = 8'hAA;
  localparam logic [7:0] KEY_B    = 8'h55;
  localparam logic [7:0] CMD_PROG = 8'hA0;
  localparam logic [7:0] CMD_ERS  = 8'h80;
  localparam logic [7:0] CMD_SEC  = 8'h20;
  localparam logic [7:0] CMD_CHIP = 8'h10;

  // strobes from control to datapath
  typedef struct packed {
    logic prog;
    logic secErase;
    logic chipErase;
    logic busy;
    logic rdStrobe;
    logic expBit7;
  } ctl_t;
endpackage

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl
  import nor_flash_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int PROG_CYC = 40,
  parameter int SEC_CYC  = 80,
  parameter int CHIP_CYC = 120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dqIn,
  output ctl_t              ctl,
  output logic [IDX_W-1:0]  tgtIdx,
  output logic [7:0]        tgtData
);
  localparam int MAX_A   = (PROG_CYC > SEC_CYC) ? PROG_CYC : SEC_CYC;
  localparam int MAX_CYC = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PDATA, S_E3, S_E4, S_E5
  } seq_t;

  logic [1:0] ceSync, weSync, oeSync;
  logic [ADDR_W-1:0] addrS1, addrS2, cycAddr;
  logic [7:0] dataS1, dataS2;
  logic wrActQ, rdActQ;
  logic wrAct, rdAct, wrBegin, wrEnd;
  seq_t seq, seqNxt;
  logic startProg, startSec, startChip;
  logic [CNT_W-1:0] busyCnt;
  logic busy, expBit7;

  // strobes and buses share one synchronizer depth
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceSync <= '1;
      weSync <= '1;
      oeSync <= '1;
      addrS1 <= '0;
      addrS2 <= '0;
      dataS1 <= '0;
      dataS2 <= '0;
      wrActQ <= 1'b0;
      rdActQ <= 1'b0;
    end else begin
      ceSync <= {ceSync[0], ceN};
      weSync <= {weSync[0], weN};
      oeSync <= {oeSync[0], oeN};
      addrS1 <= addr;
      addrS2 <= addrS1;
      dataS1 <= dqIn;
      dataS2 <= dataS1;
      wrActQ <= wrAct;
      rdActQ <= rdAct;
    end
  end

  assign wrAct   = ~ceSync[1] & ~weSync[1];
  assign rdAct   = ~ceSync[1] & ~oeSync[1];
  assign wrBegin = wrAct & ~wrActQ;
  assign wrEnd   = ~wrAct & wrActQ;
  assign busy    = (busyCnt != '0);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                               input logic [ADDR_W-1:0] aRef, input logic [7:0] dRef);
    return (a == aRef) && (d == dRef);
  endfunction

  always_comb begin
    seqNxt    = seq;
    startProg = 1'b0;
    startSec  = 1'b0;
    startChip = 1'b0;
    if (busy) begin
      seqNxt = S_IDLE;
    end else if (wrEnd) begin
      seqNxt = S_IDLE;
      unique case (seq)
        S_IDLE:  if (hit(cycAddr, dataS2, UNLOCK_A, KEY_A)) seqNxt = S_U1;
        S_U1:    if (hit(cycAddr, dataS2, UNLOCK_B, KEY_B)) seqNxt = S_U2;
        S_U2: begin
          if (hit(cycAddr, dataS2, UNLOCK_A, CMD_PROG))     seqNxt = S_PDATA;
          else if (hit(cycAddr, dataS2, UNLOCK_A, CMD_ERS)) seqNxt = S_E3;
        end
        S_PDATA: startProg = 1'b1;
        S_E3:    if (hit(cycAddr, dataS2, UNLOCK_A, KEY_A)) seqNxt = S_E4;
        S_E4:    if (hit(cycAddr, dataS2, UNLOCK_B, KEY_B)) seqNxt = S_E5;
        S_E5: begin
          if (dataS2 == CMD_SEC)                             startSec  = 1'b1;
          else if (hit(cycAddr, dataS2, UNLOCK_A, CMD_CHIP)) startChip = 1'b1;
        end
        default: seqNxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq     <= S_IDLE;
      cycAddr <= '0;
      busyCnt <= '0;
      expBit7 <= 1'b1;
    end else begin
      seq <= seqNxt;
      if (wrBegin) cycAddr <= addrS2;
      if (startProg) begin
        busyCnt <= CNT_W'(PROG_CYC);
        expBit7 <= dataS2[7];
      end else if (startSec) begin
        busyCnt <= CNT_W'(SEC_CYC);
        expBit7 <= 1'b1;
      end else if (startChip) begin
        busyCnt <= CNT_W'(CHIP_CYC);
        expBit7 <= 1'b1;
      end else if (busy) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  assign ctl.prog      = startProg;
  assign ctl.secErase  = startSec;
  assign ctl.chipErase = startChip;
  assign ctl.busy      = busy;
  assign ctl.rdStrobe  = rdAct & ~rdActQ;
  assign ctl.expBit7   = expBit7;
  assign tgtIdx        = cycAddr[IDX_W-1:0];
  assign tgtData       = dataS2;
endmodule

// File: rtl/nor_flash_dp.sv
module nor_flash_dp
  import nor_flash_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int SECTOR = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SEC_W = $clog2(SECTOR)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_t             ctl,
  input  logic [IDX_W-1:0] tgtIdx,
  input  logic [7:0]       tgtData,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic             ceN,
  input  logic             oeN,
  output logic [7:0]       dqOut,
  output logic             dqDrive
);
  logic [7:0] mem [DEPTH];
  logic tog;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (ctl.chipErase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (ctl.secErase) begin
      for (int i = 0; i < DEPTH; i++)
        if ((IDX_W'(i) >> SEC_W) == (tgtIdx >> SEC_W)) mem[i] <= 8'hFF;
    end else if (ctl.prog) begin
      mem[tgtIdx] <= mem[tgtIdx] & tgtData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tog <= 1'b0;
    else if (ctl.rdStrobe) tog <= ~tog;
  end

  assign dqOut   = ctl.busy ? {~ctl.expBit7, tog, 6'b0} : mem[rdIdx];
  assign dqDrive = ~ceN & ~oeN;
endmodule

// File: rtl/nor_flash_cmd.sv
module nor_flash_cmd
  import nor_flash_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int SECTOR   = 128,
  parameter int PROG_CYC = 40,
  parameter int SEC_CYC  = 80,
  parameter int CHIP_CYC = 120
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        weN,
  input  logic        oeN,
  input  logic [15:0] addr,
  input  logic [7:0]  dqIn,
  output logic [7:0]  dqOut,
  output logic        dqDrive
);
  localparam int IDX_W = $clog2(DEPTH);

  ctl_t ctl;
  logic [IDX_W-1:0] tgtIdx;
  logic [7:0] tgtData;

  nor_flash_ctrl #(
    .IDX_W(IDX_W), .PROG_CYC(PROG_CYC), .SEC_CYC(SEC_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .ctl(ctl), .tgtIdx(tgtIdx), .tgtData(tgtData)
  );

  nor_flash_dp #(.DEPTH(DEPTH), .SECTOR(SECTOR)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tgtIdx(tgtIdx), .tgtData(tgtData),
    .rdIdx(addr[IDX_W-1:0]), .ceN(ceN), .oeN(oeN),
    .dqOut(dqOut), .dqDrive(dqDrive)
  );
endmodule

// File: rtl/nor_flash_chk.sv
module nor_flash_chk
  import nor_flash_pkg::*;
#(
  parameter int PROG_CYC = 40,
  parameter int SEC_CYC  = 80,
  parameter int CHIP_CYC = 120
) (
  input logic       clk,
  input logic       rstN,
  input ctl_t       ctl,
  input logic [7:0] dqOut,
  input logic       dqDrive,
  input logic       ceN,
  input logic       oeN
);
  localparam int MAX_A   = (PROG_CYC > SEC_CYC) ? PROG_CYC : SEC_CYC;
  localparam int MAX_CYC = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int RUN_W   = $clog2(MAX_CYC + 2);

  logic anyStart;
  logic [RUN_W-1:0] busyRun;

  assign anyStart = ctl.prog | ctl.secErase | ctl.chipErase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         busyRun <= '0;
    else if (!ctl.busy) busyRun <= '0;
    else if (busyRun != '1) busyRun <= busyRun + 1'b1;
  end

  assert_drive_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN) |-> !dqDrive);

  assert_one_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.prog, ctl.secErase, ctl.chipErase}));

  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyStart |=> ctl.busy);

  assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(MAX_CYC));

  assert_ignore_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busy |-> !anyStart);

  assert_toggle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && ctl.rdStrobe) |=> (!ctl.busy || (dqOut[6] != $past(dqOut[6]))));
endmodule

bind nor_flash_cmd nor_flash_chk #(
  .PROG_CYC(PROG_CYC), .SEC_CYC(SEC_CYC), .CHIP_CYC(CHIP_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .ctl(ctl), .dqOut(dqOut), .dqDrive(dqDrive),
  .ceN(ceN), .oeN(oeN)
);

// File: tb/nor_flash_cmd_bench.sv
`timescale 1ns/1ps
module nor_flash_cmd_bench;
  localparam int DEPTH = 256, SECTOR = 128;
  localparam int PROG_CYC = 40, SEC_CYC = 80, CHIP_CYC = 120;

  logic clk = 1'b0, rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0] dqIn = '0;
  logic [7:0] dqOut;
  logic dqDrive;

  int checks = 0, failures = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] v, v2;
  logic drv;

  always #10 clk = ~clk;

  nor_flash_cmd #(.DEPTH(DEPTH), .SECTOR(SECTOR), .PROG_CYC(PROG_CYC),
                  .SEC_CYC(SEC_CYC), .CHIP_CYC(CHIP_CYC)) u_nor_flash_cmd (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqDrive(dqDrive));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dqIn = d; ceN = 1'b0; weN = 1'b0;
    repeat (3) @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] val, output logic drive);
    @(negedge clk); addr = a; ceN = 1'b0; oeN = 1'b0;
    repeat (5) @(negedge clk);
    val = dqOut; drive = dqDrive;
    oeN = 1'b1; ceN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic progSeq(input logic [15:0] a, input logic [7:0] d);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(a, d);
  endtask

  task automatic eraseSeq(input logic [15:0] a, input logic [7:0] cmd);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(a, cmd);
  endtask

  function automatic logic [7:0] progExp(input logic [7:0] old, input logic [7:0] d);
    return old & d;
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    void'($urandom(32'h1F2E3D4C));
    settle(3); rstN = 1'b1; settle(3);

    // R1 reset state and drive gating
    rd(16'h0000, v, drv);
    check("R1 reset data", v, 8'hFF);
    check("R1 drive on", {7'b0, drv}, 8'h01);
    @(negedge clk); ceN = 1'b0; oeN = 1'b1; @(negedge clk);
    check("R1 drive off oe high", {7'b0, dqDrive}, 8'h00);
    ceN = 1'b1; oeN = 1'b0; @(negedge clk);
    check("R1 drive off ce high", {7'b0, dqDrive}, 8'h00);
    oeN = 1'b1; settle(2);

    // R3 program
    progSeq(16'h0010, 8'h5A); model[8'h10] = progExp(model[8'h10], 8'h5A);
    settle(PROG_CYC + 10);
    rd(16'h0010, v, drv); check("R3 program", v, model[8'h10]);

    // R4 AND-only
    progSeq(16'h0010, 8'hF0); model[8'h10] = progExp(model[8'h10], 8'hF0);
    settle(PROG_CYC + 10);
    rd(16'h0010, v, drv); check("R4 clear only", v, 8'h50);

    // R9 status during program, R8 completion
    progSeq(16'h0020, 8'h12); model[8'h20] = 8'h12;
    rd(16'h0020, v, drv);
    rd(16'h0020, v2, drv);
    check("R9 dq7 program", {7'b0, v[7]}, 8'h01);
    check("R9 dq6 toggle", {7'b0, v[6] ^ v2[6]}, 8'h01);
    settle(PROG_CYC);
    rd(16'h0020, v, drv); check("R8 data after busy", v, 8'h12);

    // R2 skewed strobes: ce first, we later; we rises first
    @(negedge clk); addr = 16'h0040; dqIn = 8'h77; ceN = 1'b0;
    settle(2);
    wr(16'h5555, 8'hAA);
    ceN = 1'b1; settle(2);
    wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0);
    @(negedge clk); addr = 16'h0040; dqIn = 8'h99; ceN = 1'b0;
    settle(2); weN = 1'b0;
    @(negedge clk); addr = 16'h00C3; dqIn = 8'h3C;
    settle(2); weN = 1'b1;
    @(negedge clk); dqIn = 8'h00;
    settle(2); ceN = 1'b1; settle(3);
    model[8'h40] = 8'h3C;
    settle(PROG_CYC + 10);
    rd(16'h0040, v, drv); check("R2 skewed capture", v, 8'h3C);
    rd(16'h00C3, v, drv); check("R2 late addr unused", v, 8'hFF);

    // R5 sector erase
    progSeq(16'h0090, 8'h00); model[8'h90] = 8'h00; settle(PROG_CYC + 10);
    rd(16'h0090, v, drv); check("R5 setup", v, 8'h00);
    eraseSeq(16'h0085, 8'h20);
    rd(16'h0090, v, drv); check("R9 dq7 erase", {7'b0, v[7]}, 8'h00);
    // R10 program during erase busy
    progSeq(16'h0030, 8'h00);
    settle(SEC_CYC + 20);
    for (int i = SECTOR; i < 2 * SECTOR; i++) model[i] = 8'hFF;
    rd(16'h0090, v, drv); check("R5 sector erased", v, 8'hFF);
    rd(16'h0010, v, drv); check("R5 other sector kept", v, 8'h50);
    rd(16'h0030, v, drv); check("R10 ignored while busy", v, 8'hFF);

    // R7 wrong unlock steps
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5554, 8'hA0); wr(16'h0050, 8'h00);
    settle(PROG_CYC + 10);
    rd(16'h0050, v, drv); check("R7 bad cmd addr", v, 8'hFF);
    wr(16'h5555, 8'hAA); wr(16'h2AAB, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0050, 8'h00);
    settle(PROG_CYC + 10);
    rd(16'h0050, v, drv); check("R7 bad second step", v, 8'hFF);
    eraseSeq(16'h0010, 8'h30);
    settle(SEC_CYC + 20);
    rd(16'h0010, v, drv); check("R7 bad erase byte", v, 8'h50);

    // R6 chip erase at wrong address ignored, then real chip erase
    eraseSeq(16'h1234, 8'h10);
    settle(CHIP_CYC + 20);
    rd(16'h0010, v, drv); check("R6 wrong address", v, 8'h50);

    // constrained random programs against the model (R3, R4)
    for (int n = 0; n < 24; n++) begin
      logic [7:0] a, d;
      a = 8'($urandom_range(0, DEPTH - 1));
      d = 8'($urandom);
      progSeq({8'h00, a}, d);
      model[a] = progExp(model[a], d);
      settle(PROG_CYC + 10);
      rd({8'h00, a}, v, drv);
      check("R4 random program", v, model[a]);
    end

    eraseSeq(16'h5555, 8'h10);
    rd(16'h0010, v, drv); check("R9 dq7 chip erase", {7'b0, v[7]}, 8'h00);
    settle(CHIP_CYC + 20);
    for (int i = 0; i < DEPTH; i += 37) begin
      rd(16'(i), v, drv); check("R6 chip erased", v, 8'hFF);
    end
    summary();
  end
endmodule